// File: doc/BRIEF.md
# Multi-Mode Word DMA Channel

This block is a single DMA channel that copies 32-bit words from a source address to a destination address over two valid/ready request ports, one for reads and one for writes. Software sets up seven 32-bit registers: source start, destination start, total word count, logical block length, inter-block delay, fill constant and a control word. It then starts the channel by writing the control word with its enable bit set. Each word moves as one read handshake followed by one write handshake. In fill mode the word comes from the fill constant, so the channel issues writes only.

The transfer is split into logical blocks of a programmed number of words. At the end of each block the channel can reload the source address, the destination address or both to their programmed start values. It can also wait a programmed number of prescaled clock ticks before it starts the next block. Within a block, words are grouped into power-of-two bursts, and the write port marks the last word of each burst. When the total count has been moved, the enable bit clears and a one-cycle done pulse is raised.

Top module: `dma_chan_engine`

## Requirements
- R1: Registers sit at byte offsets 0x00 source, 0x04 destination, 0x08 total words, 0x0C block words, 0x10 delay, 0x14 fill, 0x18 control. Each reads back what was written: the full word for the first four and for fill; bits 15:0 and 17:16 for delay; bits 19:10 for control. Control bit 31 reads as the live enable.
- R2: Control bits 11:10 set the destination mode. 0 adds 4 after each word, 1 subtracts 4, and 2 keeps the address fixed.
- R3: Control bits 14:13 set the source mode. 0 adds 4, 1 subtracts 4, 2 keeps the address fixed, and 3 writes the fill register value for every word and issues no read request.
- R4: At the end of each logical block, control bit 12 set restores the destination address to its programmed start and control bit 15 set restores the source address to its programmed start.
- R5: A block length of 0 means the transfer has no block boundaries. When the total is not a multiple of the block length, the final partial block is moved and the transfer stops at exactly the total count.
- R6: Between blocks, the channel stays idle on both ports for N x P cycles. N is delay bits 15:0. P is 1, 4, 16 or 64, selected by delay bits 17:16 = 0..3. N = 0 inserts no gap, and no gap follows the final block.
- R7: Control bits 19:16 give the base-2 log of the burst length. The write port's last flag is high on the final word of each burst, on the final word of each block and on the final word of the transfer. The burst count restarts at each block boundary.
- R8: Writing control with bit 31 set while idle starts a transfer. After the total is reached, bit 31 reads 0 and done is high for exactly one cycle. With the ports always ready, done comes T x W + G x N x P + 1 cycles after the start write, where W is 2 (or 1 in fill mode) and G is the number of gaps. A total of 0 gives done with no requests.
- R9: A pending read or write request keeps its address (and data and last flag) steady until accepted, and a read and a write are never requested in the same cycle.
- R10: After reset every register reads 0, no request is pending and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| rd_valid | output | 1 | Read request pending |
| rd_addr | output | ADDR_W | Read byte address |
| rd_ready | input | 1 | Read request accepted, rd_data valid |
| rd_data | input | 32 | Read word returned with acceptance |
| wr_valid | output | 1 | Write request pending |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 32 | Write word |
| wr_last | output | 1 | Last word of a burst, block or transfer |
| wr_ready | input | 1 | Write request accepted |
| done | output | 1 | One-cycle pulse at transfer end |

## Verification
The bench sweeps every source mode against every destination mode and every reload combination, using a block length that does not divide the total. A design that reloads at the wrong time, or steps a fixed address, writes a wrong address sequence, and a fill mode that still reads shows up as unexpected read requests. Bursts are swept over four sizes, with and without block boundaries, so a burst counter that is not cleared at a block end sets the last flag on the wrong words. Gaps are timed against all four prescalers, which catches off-by-one divider or countdown errors, and the zero-total and oversized-block cases check that the channel neither hangs nor overruns.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
   localparam int REG_W = 32;

   localparam logic [4:0] OFS_SRC   = 5'h00;
   localparam logic [4:0] OFS_DST   = 5'h04;
   localparam logic [4:0] OFS_TOTAL = 5'h08;
   localparam logic [4:0] OFS_BLK   = 5'h0C;
   localparam logic [4:0] OFS_DLY   = 5'h10;
   localparam logic [4:0] OFS_FILL  = 5'h14;
   localparam logic [4:0] OFS_CTRL  = 5'h18;

   localparam int CTL_DMODE_LO = 10;
   localparam int CTL_DRELOAD  = 12;
   localparam int CTL_SMODE_LO = 13;
   localparam int CTL_SRELOAD  = 15;
   localparam int CTL_BURST_LO = 16;
   localparam int CTL_ENABLE   = 31;
   localparam int DLY_PRE_LO   = 16;

   typedef enum logic [1:0] {
      STEP_UP   = 2'd0,
      STEP_DOWN = 2'd1,
      STEP_HOLD = 2'd2,
      STEP_FILL = 2'd3
   } step_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_WRITE = 3'd2,
      ST_GAP   = 3'd3,
      ST_FIN   = 3'd4
   } chan_state_e;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        mode_i,
   output logic [ADDR_W-1:0] next_o
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   if (WORD_BYTES < 1) begin : g_bad_step
      $error("dma_addr_step: WORD_BYTES must be positive");
   end

   always_comb begin
      unique case (step_mode_e'(mode_i))
         STEP_UP:   next_o = addr_i + STEP;
         STEP_DOWN: next_o = addr_i - STEP;
         default:   next_o = addr_i;
      endcase
   end
endmodule

// File: rtl/dma_interval_timer.sv
module dma_interval_timer #(
   parameter int DLY_W = 16,
   parameter int SEL_W = 2,
   parameter int PRE_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [DLY_W-1:0] count_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             expire_o
);
   localparam int MAX_SHIFT = 2 * ((1 << SEL_W) - 1);

   if (PRE_W < MAX_SHIFT) begin : g_bad_pre
      $error("dma_interval_timer: PRE_W too narrow for the prescaler select");
   end

   logic [PRE_W-1:0] pre_q, lim_q, lim_d;
   logic [DLY_W-1:0] rem_q;
   logic             tick;

   // divide ratio is 4**sel: terminal count is that minus one
   assign lim_d    = PRE_W'((PRE_W'(1) << {sel_i, 1'b0}) - PRE_W'(1));
   assign tick     = (pre_q == lim_q);
   assign expire_o = (rem_q == DLY_W'(1)) && tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         lim_q <= '0;
         rem_q <= '0;
      end else if (load_i) begin
         pre_q <= '0;
         lim_q <= lim_d;
         rem_q <= count_i;
      end else if (rem_q != '0) begin
         if (tick) begin
            pre_q <= '0;
            rem_q <= rem_q - DLY_W'(1);
         end else begin
            pre_q <= pre_q + PRE_W'(1);
         end
      end
   end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32,
   parameter int DLY_W  = 16,
   parameter int CTL_HI = 19
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_i,
   input  logic [4:0]                    addr_i,
   input  logic [REG_W-1:0]              wdata_i,
   input  logic                          busy_i,
   output logic                          start_o,
   output logic [REG_W-1:0]              rdata_o,
   output logic [ADDR_W-1:0]             src_o,
   output logic [ADDR_W-1:0]             dst_o,
   output logic [CNT_W-1:0]              total_o,
   output logic [CNT_W-1:0]              blk_o,
   output logic [DLY_W-1:0]              dly_o,
   output logic [1:0]                    pre_o,
   output logic [REG_W-1:0]              fill_o,
   output logic [CTL_HI:CTL_DMODE_LO]    ctl_o
);
   logic ctl_wr;

   assign ctl_wr  = wr_i && (addr_i == OFS_CTRL) && !busy_i;
   assign start_o = ctl_wr && wdata_i[CTL_ENABLE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_o   <= '0;
         dst_o   <= '0;
         total_o <= '0;
         blk_o   <= '0;
         dly_o   <= '0;
         pre_o   <= '0;
         fill_o  <= '0;
         ctl_o   <= '0;
      end else if (wr_i) begin
         unique case (addr_i)
            OFS_SRC:   src_o   <= wdata_i[ADDR_W-1:0];
            OFS_DST:   dst_o   <= wdata_i[ADDR_W-1:0];
            OFS_TOTAL: total_o <= wdata_i[CNT_W-1:0];
            OFS_BLK:   blk_o   <= wdata_i[CNT_W-1:0];
            OFS_DLY: begin
               dly_o <= wdata_i[DLY_W-1:0];
               pre_o <= wdata_i[DLY_PRE_LO +: 2];
            end
            OFS_FILL:  fill_o  <= wdata_i;
            OFS_CTRL:  if (ctl_wr) ctl_o <= wdata_i[CTL_HI:CTL_DMODE_LO];
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         OFS_SRC:   rdata_o = REG_W'(src_o);
         OFS_DST:   rdata_o = REG_W'(dst_o);
         OFS_TOTAL: rdata_o = REG_W'(total_o);
         OFS_BLK:   rdata_o = REG_W'(blk_o);
         OFS_DLY: begin
            rdata_o[DLY_W-1:0]        = dly_o;
            rdata_o[DLY_PRE_LO +: 2]  = pre_o;
         end
         OFS_FILL:  rdata_o = fill_o;
         OFS_CTRL: begin
            rdata_o[CTL_HI:CTL_DMODE_LO] = ctl_o;
            rdata_o[CTL_ENABLE]          = busy_i;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 32,
   parameter int DLY_W   = 16,
   parameter int BURST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [4:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ready,
   input  logic [31:0]       rd_data,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [31:0]       wr_data,
   output logic              wr_last,
   input  logic              wr_ready,
   output logic              done
);
   localparam int CTL_HI = CTL_BURST_LO + BURST_W - 1;

   if (ADDR_W < 3 || ADDR_W > REG_W) begin : g_bad_addr
      $error("dma_chan_engine: ADDR_W out of range");
   end
   if (CNT_W < 2 || CNT_W > REG_W) begin : g_bad_cnt
      $error("dma_chan_engine: CNT_W out of range");
   end
   if (DLY_W < 1 || DLY_W > DLY_PRE_LO) begin : g_bad_dly
      $error("dma_chan_engine: DLY_W out of range");
   end
   if (BURST_W < 1 || CTL_HI >= CTL_ENABLE || (1 << BURST_W) > CNT_W) begin : g_bad_burst
      $error("dma_chan_engine: BURST_W out of range");
   end

   // configuration
   logic                       start;
   logic [ADDR_W-1:0]          src_cfg, dst_cfg;
   logic [CNT_W-1:0]           total_cfg, blk_cfg;
   logic [DLY_W-1:0]           dly_cfg;
   logic [1:0]                 pre_cfg;
   logic [31:0]                fill_cfg;
   logic [CTL_HI:CTL_DMODE_LO] ctl_cfg;

   // run state
   chan_state_e       state_q;
   logic [ADDR_W-1:0] cur_src_q, cur_dst_q, src_next, dst_next;
   logic [31:0]       data_q;
   logic [CNT_W-1:0]  moved_q, blk_cnt_q, burst_cnt_q;
   logic [CNT_W-1:0]  moved_nx, burst_len;
   logic              busy, fill_mode, gap_active, gap_expire, timer_load;
   logic              last_word, blk_end, burst_end, start_fill;
   logic              rd_hs, wr_hs;
   logic [1:0]        dmode, smode;
   chan_state_e       run_state;

   dma_chan_regs #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .DLY_W  (DLY_W),
      .CTL_HI (CTL_HI)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (reg_wr),
      .addr_i  (reg_addr),
      .wdata_i (reg_wdata),
      .busy_i  (busy),
      .start_o (start),
      .rdata_o (reg_rdata),
      .src_o   (src_cfg),
      .dst_o   (dst_cfg),
      .total_o (total_cfg),
      .blk_o   (blk_cfg),
      .dly_o   (dly_cfg),
      .pre_o   (pre_cfg),
      .fill_o  (fill_cfg),
      .ctl_o   (ctl_cfg)
   );

   assign dmode      = ctl_cfg[CTL_DMODE_LO +: 2];
   assign smode      = ctl_cfg[CTL_SMODE_LO +: 2];
   assign fill_mode  = (smode == 2'(STEP_FILL));
   assign start_fill = (reg_wdata[CTL_SMODE_LO +: 2] == 2'(STEP_FILL));
   assign burst_len  = CNT_W'(1) << ctl_cfg[CTL_BURST_LO +: BURST_W];
   assign run_state  = fill_mode ? ST_WRITE : ST_READ;

   dma_addr_step #(.ADDR_W(ADDR_W)) u_src_step (
      .addr_i (cur_src_q),
      .mode_i (smode),
      .next_o (src_next)
   );

   dma_addr_step #(.ADDR_W(ADDR_W)) u_dst_step (
      .addr_i (cur_dst_q),
      .mode_i (dmode),
      .next_o (dst_next)
   );

   assign busy       = (state_q == ST_READ) || (state_q == ST_WRITE) || (state_q == ST_GAP);
   assign gap_active = (state_q == ST_GAP);
   assign rd_hs      = (state_q == ST_READ) && rd_ready;
   assign wr_hs      = (state_q == ST_WRITE) && wr_ready;
   assign moved_nx   = moved_q + CNT_W'(1);
   assign last_word  = (moved_nx == total_cfg);
   assign blk_end    = (blk_cfg != '0) && ((blk_cnt_q + CNT_W'(1)) == blk_cfg);
   assign burst_end  = ((burst_cnt_q + CNT_W'(1)) == burst_len);
   assign timer_load = wr_hs && !last_word && blk_end;

   dma_interval_timer #(.DLY_W(DLY_W)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (timer_load),
      .count_i  (dly_cfg),
      .sel_i    (pre_cfg),
      .expire_o (gap_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cur_src_q   <= '0;
         cur_dst_q   <= '0;
         data_q      <= '0;
         moved_q     <= '0;
         blk_cnt_q   <= '0;
         burst_cnt_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  cur_src_q   <= src_cfg;
                  cur_dst_q   <= dst_cfg;
                  moved_q     <= '0;
                  blk_cnt_q   <= '0;
                  burst_cnt_q <= '0;
                  if (total_cfg == '0)
                     state_q <= ST_FIN;
                  else
                     state_q <= start_fill ? ST_WRITE : ST_READ;
               end
            end
            ST_READ: begin
               if (rd_hs) begin
                  data_q    <= rd_data;
                  cur_src_q <= src_next;
                  state_q   <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (wr_hs) begin
                  moved_q   <= moved_nx;
                  cur_dst_q <= dst_next;
                  if (last_word) begin
                     state_q <= ST_FIN;
                  end else if (blk_end) begin
                     blk_cnt_q   <= '0;
                     burst_cnt_q <= '0;
                     if (ctl_cfg[CTL_SRELOAD]) cur_src_q <= src_cfg;
                     if (ctl_cfg[CTL_DRELOAD]) cur_dst_q <= dst_cfg;
                     state_q <= (dly_cfg != '0) ? ST_GAP : run_state;
                  end else begin
                     blk_cnt_q   <= blk_cnt_q + CNT_W'(1);
                     burst_cnt_q <= burst_end ? '0 : burst_cnt_q + CNT_W'(1);
                     state_q     <= run_state;
                  end
               end
            end
            ST_GAP: begin
               if (gap_expire) state_q <= run_state;
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_valid = (state_q == ST_READ);
   assign rd_addr  = cur_src_q;
   assign wr_valid = (state_q == ST_WRITE);
   assign wr_addr  = cur_dst_q;
   assign wr_data  = fill_mode ? fill_cfg : data_q;
   assign wr_last  = (state_q == ST_WRITE) && (last_word || blk_end || burst_end);
   assign done     = (state_q == ST_FIN);
endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              fill_mode,
   input logic              gap_active,
   input logic              rd_valid,
   input logic              rd_ready,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [31:0]       wr_data,
   input logic              wr_last,
   input logic              done
);
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !rd_valid && !wr_valid); // R8

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R9

   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_last)); // R9

   AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && wr_valid)); // R9

   AST_FILL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      busy && fill_mode |-> !rd_valid); // R3

   AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      gap_active |-> !rd_valid && !wr_valid); // R6
endmodule

bind dma_chan_engine dma_chan_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .fill_mode  (fill_mode),
   .gap_active (gap_active),
   .rd_valid   (rd_valid),
   .rd_ready   (rd_ready),
   .rd_addr    (rd_addr),
   .wr_valid   (wr_valid),
   .wr_ready   (wr_ready),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .wr_last    (wr_last),
   .done       (done)
);

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LOGN = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        rd_valid, wr_valid, wr_last, done;
   logic [31:0] rd_addr, wr_addr, wr_data, rd_data;
   logic        rd_ready = 1'b1;
   logic        wr_ready = 1'b1;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit stall = 1'b0;
   bit finished = 1'b0;
   int n_rd = 0;
   int n_wr = 0;
   logic [31:0] rd_log [LOGN];
   logic [31:0] wa_log [LOGN];
   logic [31:0] wd_log [LOGN];
   logic        wl_log [LOGN];

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return {a[15:0] ^ 16'hA5C3, ~a[15:0]};
   endfunction

   assign rd_data = mem_word(rd_addr);

   dma_chan_engine u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_last(wr_last),
      .wr_ready(wr_ready), .done(done)
   );

   // ready pattern and handshake log, all away from the rising edge
   always @(negedge clk) begin
      cyc = cyc + 1;
      rd_ready = !stall || (cyc % 3 != 1);
      wr_ready = !stall || (cyc % 4 != 2);
      if (rst_n && rd_valid && rd_ready) begin
         if (n_rd < LOGN) rd_log[n_rd] = rd_addr;
         n_rd++;
      end
      if (rst_n && wr_valid && wr_ready) begin
         if (n_wr < LOGN) begin
            wa_log[n_wr] = wr_addr;
            wd_log[n_wr] = wr_data;
            wl_log[n_wr] = wr_last;
         end
         n_wr++;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rreg(input logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   function automatic logic [31:0] stepped(input logic [31:0] a, input int mode);
      if (mode == 0) return a + 32'd4;
      if (mode == 1) return a - 32'd4;
      return a;
   endfunction

   // program, start, wait for done, compare against the arithmetic model
   task automatic run(input logic [31:0] src, input logic [31:0] dst, input int total, input int blk,
                      input int dly, input int pre, input logic [31:0] fillv,
                      input int sm, input int dm, input bit rs, input bit rdl, input int bl,
                      input bit timed, input string req);
      logic [31:0] ctl, s, d, v, ex_a, ex_d;
      int n, bi, bc, nrd_exp, gaps, w, ir;
      bit ex_l;
      wreg(5'h00, src);
      wreg(5'h04, dst);
      wreg(5'h08, total);
      wreg(5'h0C, blk);
      wreg(5'h10, (pre << 16) | dly);
      wreg(5'h14, fillv);
      ctl = (32'(dm) << 10) | (32'(rdl) << 12) | (32'(sm) << 13) | (32'(rs) << 15) | (32'(bl) << 16);
      n_rd = 0;
      n_wr = 0;
      wreg(5'h18, ctl | 32'h8000_0000);
      n = 1;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
      end
      chk(done === 1'b1, {req, " R8 done seen"}, 32'(done), 1);
      w = (sm == 3) ? 1 : 2;
      gaps = (blk == 0 || total == 0 || dly == 0) ? 0 : ((total + blk - 1) / blk - 1);
      if (timed)
         chk(n == total * w + gaps * dly * (1 << (2 * pre)) + 1, {req, " R6 R8 done cycle"},
             32'(n), 32'(total * w + gaps * dly * (1 << (2 * pre)) + 1));
      rreg(5'h18, v);
      chk(v[31] == 1'b0, {req, " R8 enable cleared"}, v, ctl);
      @(negedge clk);
      chk(done == 1'b0, {req, " R8 done one cycle"}, 32'(done), 0);
      // model
      s = src; d = dst; bi = 0; bc = 0; ir = 0;
      nrd_exp = (sm == 3) ? 0 : total;
      chk(n_wr == total, {req, " R5 write count"}, 32'(n_wr), 32'(total));
      chk(n_rd == nrd_exp, {req, " R3 read count"}, 32'(n_rd), 32'(nrd_exp));
      for (int i = 0; i < total && i < LOGN; i++) begin
         ex_a = d;
         ex_d = (sm == 3) ? fillv : mem_word(s);
         ex_l = (i == total - 1) || (blk != 0 && bi + 1 == blk) || (bc + 1 == (1 << bl));
         if (sm != 3 && ir < n_rd && ir < LOGN) begin
            chk(rd_log[ir] == s, {req, " R3 R4 read addr"}, rd_log[ir], s);
            ir++;
         end
         if (i < n_wr) begin
            chk(wa_log[i] == ex_a, {req, " R2 R4 write addr"}, wa_log[i], ex_a);
            chk(wd_log[i] == ex_d, {req, " R3 write data"}, wd_log[i], ex_d);
            chk(wl_log[i] == ex_l, {req, " R7 last flag"}, 32'(wl_log[i]), 32'(ex_l));
         end
         s = (sm == 3) ? s : stepped(s, sm);
         d = stepped(d, dm);
         if (blk != 0 && bi + 1 == blk) begin
            bi = 0; bc = 0;
            if (rs) s = src;
            if (rdl) d = dst;
         end else begin
            bi++;
            bc = (bc + 1 == (1 << bl)) ? 0 : bc + 1;
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(rd_valid == 1'b0 && wr_valid == 1'b0, "R10 no request in reset", {rd_valid, wr_valid}, 0);
      chk(done == 1'b0, "R10 done low", 32'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int a = 0; a < 7; a++) begin
         rreg(5'(a * 4), v);
         chk(v == 32'd0, "R10 register reset", v, 0);
      end
      // R1 register map readback, control written without enable
      wreg(5'h00, 32'h1234_5678); wreg(5'h04, 32'h9ABC_DEF0);
      wreg(5'h08, 32'hDEAD_BEEF); wreg(5'h0C, 32'h0BAD_F00D);
      wreg(5'h10, 32'hFFFF_FFFF); wreg(5'h14, 32'hCAFE_0001);
      wreg(5'h18, 32'h7FFF_FFFF);
      rreg(5'h00, v); chk(v == 32'h1234_5678, "R1 source", v, 32'h1234_5678);
      rreg(5'h04, v); chk(v == 32'h9ABC_DEF0, "R1 destination", v, 32'h9ABC_DEF0);
      rreg(5'h08, v); chk(v == 32'hDEAD_BEEF, "R1 total", v, 32'hDEAD_BEEF);
      rreg(5'h0C, v); chk(v == 32'h0BAD_F00D, "R1 block", v, 32'h0BAD_F00D);
      rreg(5'h10, v); chk(v == 32'h0003_FFFF, "R1 delay", v, 32'h0003_FFFF);
      rreg(5'h14, v); chk(v == 32'hCAFE_0001, "R1 fill", v, 32'hCAFE_0001);
      rreg(5'h18, v); chk(v == 32'h000F_FC00, "R1 control", v, 32'h000F_FC00);
      @(negedge clk);
      chk(rd_valid == 1'b0 && wr_valid == 1'b0, "R8 no start without enable", {rd_valid, wr_valid}, 0);

      // R2 R3 R4 R5: every mode pair and reload pair, partial last block
      for (int sm = 0; sm < 4; sm++)
         for (int dm = 0; dm < 3; dm++)
            for (int rl = 0; rl < 4; rl++) begin
               stall = ((sm + dm + rl) % 2) == 1;
               run(32'h0000_1000, 32'h0000_8000, 5, 3, 0, 0, 32'h5EED_0000 + 32'(sm * 16 + dm * 4 + rl),
                   sm, dm, rl[0], rl[1], 1, !stall, "R2 R4 sweep");
            end
      stall = 1'b0;

      // R7 burst sizes, with and without blocks
      for (int bl = 0; bl < 4; bl++) begin
         run(32'h200, 32'h400, 9, 0, 0, 0, 0, 0, 0, 0, 0, bl, 1, "R7 burst no blocks");
         run(32'h200, 32'h400, 9, 5, 0, 0, 0, 0, 0, 0, 0, bl, 1, "R7 burst in blocks");
      end

      // R6 gap length over all prescalers, read and fill paths
      for (int pre = 0; pre < 4; pre++)
         for (int k = 0; k < 2; k++) begin
            run(32'h40, 32'h80, 4, 2, (k == 0) ? 1 : 3, pre, 32'h0F0F_0F0F, (k == 0) ? 0 : 3, 0, 0, 0, 0, 1,
                "R6 gap prescale");
         end
      run(32'h40, 32'h80, 6, 2, 0, 3, 0, 0, 0, 0, 0, 0, 1, "R6 zero delay");

      // R8 R5 boundaries
      run(32'h40, 32'h80, 0, 2, 5, 1, 0, 0, 0, 1, 1, 0, 1, "R8 zero total");
      run(32'h40, 32'h80, 3, 8, 7, 2, 0, 0, 1, 1, 1, 2, 1, "R5 block longer than total");
      run(32'hFFF0, 32'h10, 7, 3, 2, 1, 0, 1, 0, 1, 1, 3, 1, "R5 R4 partial block reload");
      stall = 1'b1;
      run(32'hFFF0, 32'h10, 7, 3, 2, 1, 0, 1, 0, 1, 1, 3, 0, "R9 stalled ports");
      stall = 1'b0;

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
      $finish;
   end
endmodule